// File: doc/BRIEF.md
# Johnson Decade Counter with Decoded Outputs

This block divides a stream of count events by ten. It keeps its state in a five-bit twisted-ring (Johnson) register, and decodes that register into ten outputs of which one is high at a time. It also drives a carry output that is high for the first half of the ten-state cycle. The carry rises as the count wraps from nine back to zero, so it can drive the count input of a following stage when stages are cascaded.

A count event arrives along one of two paths. The first is a rising edge of the count input while the hold input is low. The second is a falling edge of the hold input while the count input is high. Both inputs are asynchronous to the block. Each passes through a synchronizer and an edge detector running on a free-running system clock. A level-sensitive master clear forces count zero and overrides both count paths. If the ring register ever holds a pattern outside the legal sequence, it is steered back to count zero by the next count event or by a clear.

Top module: `decade_ring_counter`

## Requirements
- R1: While the ring holds a legal pattern, exactly one bit of `dec_o` is high. Bit k is high at count k. Each count event moves the high bit from index k to index k+1, and from index 9 it wraps to index 0.
- R2: A rising edge of `count_i` while `hold_i` is low advances the count by one.
- R3: A falling edge of `hold_i` while `count_i` is high advances the count by one.
- R4: None of these advance the count: a rising edge of `count_i` while `hold_i` is high, a falling edge of `count_i`, a rising edge of `hold_i`, or a falling edge of `hold_i` while `count_i` is low.
- R5: `carry_o` is 1 while the count is 0 to 4 and 0 while it is 5 to 9. It therefore rises on the wrap from count 9 to count 0.
- R6: While `clear_i` is high, `dec_o` equals 10'b0000000001 and `carry_o` is 1 from the next system clock edge on. Count events are ignored while `clear_i` is high.
- R7: If a rising `count_i` edge and a falling `hold_i` edge are detected in the same system clock cycle, the count advances by exactly one.
- R8: If the ring holds a pattern outside the ten legal states, the next count event or a `clear_i` puts it at count 0.
- R9: Take a change of `count_i` or `hold_i` that sets up a count event. The outputs keep their old value through the second rising edge of `clk_i` after the change, and show the new count after the third.
- R10: After `rst_ni` is released the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| count_i | input | 1 | Count pulse input, asynchronous |
| hold_i | input | 1 | Inhibit input, asynchronous; its falling edge is a second count path |
| clear_i | input | 1 | Master clear, active high, level-sensitive |
| dec_o | output | 10 | One-hot decoded count |
| carry_o | output | 1 | High during counts 0 to 4 |

## Verification
A wrong ring pattern shows at the ports at once. The decoded word stops being one-hot, or it is one-hot at the wrong index, and the carry can disagree with the half of the cycle the high bit sits in. A step that is lost or doubled shows up as an index offset three clock edges after the input change that caused it. An injected illegal pattern must be gone after one further count event. The bench compares every settled output against an integer model of the count modulo ten, so any step error shows at the first check after it.

// File: rtl/decade_pkg.sv
package decade_pkg;

   // Number of bit positions in a ring word where neighbours differ
   function automatic int unsigned ring_breaks(input logic [31:0] word, input int unsigned width);
      int unsigned n;
      n = 0;
      for (int unsigned i = 0; i + 1 < width; i++) begin
         if (word[i] != word[i+1]) n++;
      end
      return n;
   endfunction

   typedef enum logic [1:0] {
      STEP_NONE  = 2'd0,
      STEP_CLEAR = 2'd1,
      STEP_ADV   = 2'd2,
      STEP_FIX   = 2'd3
   } ring_op_e;

endpackage

// File: rtl/decade_sync.sv
module decade_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned DEPTH  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("decade_sync: WIDTH must be at least 1");
   end

   if (DEPTH == 0) begin : g_bypass
      assign sync_o = async_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [DEPTH];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
         end
      end

      assign sync_o = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/decade_edge.sv
module decade_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cnt_lvl_i,
   input  logic hold_lvl_i,
   output logic cnt_rise_o,
   output logic hold_fall_o,
   output logic step_o
);

   logic cnt_prev_q;
   logic hold_prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_prev_q  <= 1'b0;
         hold_prev_q <= 1'b0;
      end else begin
         cnt_prev_q  <= cnt_lvl_i;
         hold_prev_q <= hold_lvl_i;
      end
   end

   logic path_cnt;
   logic path_hold;

   always_comb begin
      cnt_rise_o  = cnt_lvl_i & ~cnt_prev_q;
      hold_fall_o = ~hold_lvl_i & hold_prev_q;
      path_cnt    = cnt_rise_o & ~hold_lvl_i;
      path_hold   = hold_fall_o & cnt_lvl_i;
      // Both paths at once still make a single step
      step_o      = path_cnt | path_hold;
   end

endmodule

// File: rtl/decade_ring.sv
module decade_ring
   import decade_pkg::*;
#(
   parameter int unsigned STAGES = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              step_i,
   output logic [STAGES-1:0] state_q,
   output logic              legal_o
);

   if (STAGES < 2 || STAGES > 32) begin : g_bad_stages
      $error("decade_ring: STAGES must lie in 2..32");
   end

   ring_op_e          op;
   logic [STAGES-1:0] state_d;

   always_comb begin
      legal_o = ring_breaks(32'(state_q), STAGES) <= 1;
      if (clear_i)            op = STEP_CLEAR;
      else if (!step_i)       op = STEP_NONE;
      else if (legal_o)       op = STEP_ADV;
      else                    op = STEP_FIX;

      unique case (op)
         STEP_ADV:   state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
         STEP_CLEAR,
         STEP_FIX:   state_d = '0;
         default:    state_d = state_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= '0;
      else         state_q <= state_d;
   end

endmodule

// File: rtl/decade_decode.sv
module decade_decode #(
   parameter int unsigned STAGES  = 5,
   localparam int unsigned NUM_OUT = 2 * STAGES
) (
   input  logic [STAGES-1:0]  ring_i,
   output logic [NUM_OUT-1:0] dec_o,
   output logic               carry_o
);

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      if (k == 0) begin : g_first
         assign dec_o[k] = ~ring_i[STAGES-1] & ~ring_i[0];
      end else if (k < STAGES) begin : g_fill
         assign dec_o[k] = ring_i[k-1] & ~ring_i[k];
      end else if (k == STAGES) begin : g_full
         assign dec_o[k] = ring_i[STAGES-1] & ring_i[0];
      end else begin : g_drain
         assign dec_o[k] = ~ring_i[k-STAGES-1] & ring_i[k-STAGES];
      end
   end

   // First half of the cycle: top ring bit still clear
   assign carry_o = ~ring_i[STAGES-1];

endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter #(
   parameter int unsigned STAGES      = 5,
   parameter int unsigned SYNC_DEPTH  = 2,
   localparam int unsigned NUM_OUT    = 2 * STAGES
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               count_i,
   input  logic               hold_i,
   input  logic               clear_i,
   output logic [NUM_OUT-1:0] dec_o,
   output logic               carry_o
);

   if (SYNC_DEPTH > 4) begin : g_bad_sync
      $error("decade_ring_counter: SYNC_DEPTH above 4 is not supported");
   end

   logic [1:0]        lvl;
   logic              cnt_rise;
   logic              hold_fall;
   logic              step;
   logic [STAGES-1:0] ring;
   logic              legal;

   decade_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i ({hold_i, count_i}),
      .sync_o  (lvl)
   );

   decade_edge u_edge (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cnt_lvl_i   (lvl[0]),
      .hold_lvl_i  (lvl[1]),
      .cnt_rise_o  (cnt_rise),
      .hold_fall_o (hold_fall),
      .step_o      (step)
   );

   decade_ring #(.STAGES(STAGES)) u_ring (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .step_i  (step),
      .state_q (ring),
      .legal_o (legal)
   );

   decade_decode #(.STAGES(STAGES)) u_dec (
      .ring_i  (ring),
      .dec_o   (dec_o),
      .carry_o (carry_o)
   );

endmodule

// File: rtl/decade_ring_counter_chk.sv
module decade_ring_counter_chk #(
   parameter int unsigned NUM_OUT = 10
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               clear_i,
   input logic               step,
   input logic               cnt_rise,
   input logic               hold_fall,
   input logic               lvl_hold,
   input logic               lvl_cnt,
   input logic               legal,
   input logic [NUM_OUT-1:0] dec_o,
   input logic               carry_o
);

   logic [NUM_OUT-1:0] rot;
   assign rot = {dec_o[NUM_OUT-2:0], dec_o[NUM_OUT-1]};

   AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      legal |-> $onehot(dec_o)); // R1

   AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && legal && !clear_i) |=> (dec_o == $past(rot))); // R1

   AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step && !clear_i) |=> (!legal || ($stable(dec_o) && $stable(carry_o)))); // R4

   AST_NO_BLOCKED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_rise && lvl_hold && !hold_fall) |-> !step); // R4

   AST_FALL_NEEDS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_fall && !lvl_cnt && !cnt_rise) |-> !step); // R4

   AST_CARRY_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      legal |-> (carry_o == (|dec_o[NUM_OUT/2-1:0]))); // R5

   AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (dec_o == NUM_OUT'(1) && carry_o)); // R6

   AST_FIX_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && !legal && !clear_i) |=> (dec_o == NUM_OUT'(1))); // R8

endmodule

bind decade_ring_counter decade_ring_counter_chk #(.NUM_OUT(NUM_OUT)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .clear_i   (clear_i),
   .step      (step),
   .cnt_rise  (cnt_rise),
   .hold_fall (hold_fall),
   .lvl_hold  (lvl[1]),
   .lvl_cnt   (lvl[0]),
   .legal     (legal),
   .dec_o     (dec_o),
   .carry_o   (carry_o)
);

// File: tb/test_decade_ring_counter.sv
module test_decade_ring_counter;

   localparam time CLK_PERIOD = 10ns;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       count_i = 1'b0;
   logic       hold_i = 1'b0;
   logic       clear_i = 1'b0;
   logic [9:0] dec_o;
   logic       carry_o;

   int n_tests = 0;
   int n_fail  = 0;
   int model   = 0;
   bit pending_fix = 1'b0;
   bit finished = 1'b0;
   logic cp_l = 1'b0;
   logic en_l = 1'b0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   decade_ring_counter i_decade_ring_counter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .count_i (count_i),
      .hold_i  (hold_i),
      .clear_i (clear_i),
      .dec_o   (dec_o),
      .carry_o (carry_o)
   );

   function automatic logic [9:0] exp_dec(input int c);
      return 10'(1) << c;
   endfunction

   function automatic logic exp_carry(input int c);
      return c < 5;
   endfunction

   task automatic check(input string req);
      n_tests++;
      if (dec_o !== exp_dec(model) || carry_o !== exp_carry(model)) begin
         n_fail++;
         $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
                  req, dec_o, carry_o, exp_dec(model), exp_carry(model));
      end
   endtask

   // Drive new levels at a falling edge, update the model, wait to settle, check
   task automatic apply(input logic cp, input logic en, input logic mr, input string req);
      bit ev;
      @(negedge clk_i);
      ev = (cp && !cp_l && !en) || (!en && en_l && cp);
      if (mr) begin
         model = 0;
         pending_fix = 1'b0;
      end else if (ev) begin
         model = pending_fix ? 0 : (model + 1) % 10;
         pending_fix = 1'b0;
      end
      count_i = cp;
      hold_i  = en;
      clear_i = mr;
      cp_l = cp;
      en_l = en;
      repeat (4) @(negedge clk_i);
      check(req);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0417));
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (2) @(negedge clk_i);
      check("R10 reset state");

      // R2: ten count-input rises with hold low, including wrap 9 -> 0 and carry
      for (int i = 0; i < 10; i++) begin
         apply(1'b1, 1'b0, 1'b0, "R2 count rise");
         apply(1'b0, 1'b0, 1'b0, "R4 count fall ignored");
      end
      check("R1 wrap to zero after ten steps");
      check("R5 carry high after wrap");

      // R4: rise while hold high is blocked, hold rise with count low ignored
      apply(1'b0, 1'b1, 1'b0, "R4 hold rise ignored");
      apply(1'b1, 1'b1, 1'b0, "R4 count rise blocked by hold");
      // R3: hold falls while count high
      apply(1'b1, 1'b0, 1'b0, "R3 hold fall advances");
      apply(1'b0, 1'b0, 1'b0, "R4 count fall ignored");
      apply(1'b0, 1'b1, 1'b0, "R4 hold rise ignored");
      apply(1'b0, 1'b0, 1'b0, "R4 hold fall with count low ignored");

      // R7: count rises and hold falls together -> one step
      apply(1'b0, 1'b1, 1'b0, "R4 setup");
      apply(1'b1, 1'b0, 1'b0, "R7 simultaneous paths single step");
      apply(1'b0, 1'b0, 1'b0, "R4 count fall ignored");

      // R9: latency of three clock edges
      @(negedge clk_i);
      count_i = 1'b1;
      cp_l = 1'b1;
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      check("R9 unchanged after two edges");
      model = (model + 1) % 10;
      @(negedge clk_i);
      check("R9 updated after third edge");
      apply(1'b0, 1'b0, 1'b0, "R4 count fall ignored");

      // R6: clear mid-cycle, events ignored while clear held
      apply(1'b1, 1'b0, 1'b0, "R2 count rise");
      apply(1'b0, 1'b0, 1'b1, "R6 clear mid-cycle");
      apply(1'b1, 1'b0, 1'b1, "R6 count rise ignored under clear");
      apply(1'b1, 1'b1, 1'b1, "R6 hold rise under clear");
      apply(1'b1, 1'b0, 1'b1, "R6 hold fall ignored under clear");
      apply(1'b0, 1'b0, 1'b0, "R6 release clear");

      // R8: illegal pattern repaired by the next count event
      apply(1'b1, 1'b0, 1'b0, "R2 count rise");
      apply(1'b0, 1'b0, 1'b0, "R4 count fall ignored");
      @(negedge clk_i);
      force i_decade_ring_counter.u_ring.state_q = 5'b01010;
      @(negedge clk_i);
      release i_decade_ring_counter.u_ring.state_q;
      pending_fix = 1'b1;
      apply(1'b1, 1'b0, 1'b0, "R8 illegal repaired by count event");
      apply(1'b0, 1'b0, 1'b0, "R4 count fall ignored");
      apply(1'b1, 1'b0, 1'b0, "R8 counting resumes after repair");

      // R8: illegal pattern repaired by clear
      @(negedge clk_i);
      force i_decade_ring_counter.u_ring.state_q = 5'b10110;
      @(negedge clk_i);
      release i_decade_ring_counter.u_ring.state_q;
      apply(1'b1, 1'b0, 1'b1, "R8 illegal repaired by clear");
      apply(1'b1, 1'b0, 1'b0, "R6 release clear");

      // Random stimulus: R1 R2 R3 R4 R5 R6 against the modulo-10 model
      for (int i = 0; i < 400; i++) begin
         logic cp, en, mr;
         int r;
         r  = int'($urandom_range(0, 99));
         cp = (r < 45) ? ~cp_l : cp_l;
         en = ($urandom_range(0, 99) < 35) ? ~en_l : en_l;
         mr = ($urandom_range(0, 99) < 6);
         apply(cp, en, mr, "R1 R2 R3 R4 R5 R6 random");
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule